// File: doc/BRIEF.md
# Folded Point-Pair Coordinate Rotator

This block turns one quantized orientation into a full set of rotated sampling offsets for a binary descriptor. A key-point arrives as an angle bin (0 to 24) together with a one-cycle start strobe. The block then walks a fixed list of 256 point-pairs (512 sampling points) and rotates each point by the selected angle. It emits the results as signed integer offsets that a downstream stage can use directly as window-buffer addresses.

Key-points are sparse, so a single rotation datapath is shared across the whole list. The datapath is eight point rotators wide, which is four pairs per cycle, one per descriptor lane. The whole list therefore takes 64 consecutive output cycles. Products are formed with shift-and-add logic against 7-bit signed trigonometric coefficients. The results pass through a nine-stage pipeline that rounds and clamps them. A busy flag covers the whole run, from acceptance until the last group leaves. A done flag marks the final group.

Top module: `pair_rotator`

## Requirements
- R1: When `start_i` is high at a rising edge and `busy_o` is low, a run begins with the angle bin on `bin_i`, and `busy_o` is high after that edge.
- R2: Sampling point p (0 to 511) has x = ((7p + 3) mod 27) - 13 and y = ((5p + 3*floor(p/32) + 1) mod 27) - 13. Pair i consists of points 2i (first) and 2i+1 (second).
- R3: For bin k, the cosine coefficient is round(64*cos(2*pi*k/25)) and the sine coefficient is round(64*sin(2*pi*k/25)). Both are clamped to the signed 7-bit range -64..63.
- R4: Each point is mapped to rx = (C*x - S*y)/64 and ry = (S*x + C*y)/64. The quotient is rounded to the nearest integer, with exact halves rounded away from zero.
- R5: Every rotated value is clamped to the window range -15..+15. The input list guarantees that clamping occurs for some bins.
- R6: Each valid cycle carries four pairs as 80 bits. Lane j (0 to 3) occupies bits [20j+19:20j], holding the first point's rx at [4:0], its ry at [9:5], the second point's rx at [14:10] and its ry at [19:15]. Output cycle g carries pairs 4g to 4g+3.
- R7: `out_vld_o` is first high after the ninth rising edge counted from the accepting edge (that edge included). It then stays high for 64 consecutive cycles.
- R8: `out_done_o` is high only in the cycle that carries pairs 252 to 255. `busy_o` falls at the same edge that presents that cycle.
- R9: A start strobe while `busy_o` is high is ignored. The run in progress continues unchanged, and no extra outputs appear.
- R10: A bin value above 24 is treated as bin 24.
- R11: After a synchronous reset, `busy_o`, `out_vld_o` and `out_done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe for one key-point |
| bin_i | input | 5 | Angle bin, 0 to 24 |
| busy_o | output | 1 | Run in progress |
| out_vld_o | output | 1 | Output group valid |
| out_done_o | output | 1 | Final group of the run |
| out_coord_o | output | 80 | Four rotated pairs, packed as in R6 |

## Verification
For every accepted start, the scoreboard stamps output group g as due at the cycle count taken at the start strobe plus 9 + g. The monitor samples on the falling edge and requires each group to arrive in exactly its due cycle. An early, late or extra group is reported against R7 or R9. The done flag is expected only with group 63, and busy must already be low when that group is sampled. The busy check that follows acceptance is taken on the first falling edge after the accepting edge.

// File: rtl/pair_rot_pkg.sv
package pair_rot_pkg;

    localparam int COORD_W  = 5;
    localparam int COEF_W   = 7;
    localparam int FRAC     = 6;
    localparam int BIN_W    = 5;
    localparam int NUM_BINS = 25;
    localparam int PROD_W   = COORD_W + COEF_W;
    localparam int SUM_W    = PROD_W + 1;
    localparam int RMAG_W   = SUM_W - FRAC;

    typedef logic signed [COORD_W-1:0] coord_t;
    typedef logic signed [COEF_W-1:0]  coef_t;
    typedef logic signed [PROD_W-1:0]  prod_t;
    typedef logic signed [SUM_W-1:0]   sum_t;

    typedef struct packed {
        coord_t x;
        coord_t y;
    } point_t;

    typedef struct packed {
        coef_t c;
        coef_t s;
    } trig_t;

    // Fixed sampling pattern, generated from the point index.
    function automatic point_t point_at(input int p);
        point_t pt;
        pt.x = coord_t'(((p * 7 + 3) % 27) - 13);
        pt.y = coord_t'(((p * 5 + (p / 32) * 3 + 1) % 27) - 13);
        return pt;
    endfunction

    // Coefficients in Q1.6, cos(0) held at the largest positive code.
    function automatic trig_t trig_lut(input logic [BIN_W-1:0] k);
        int c;
        int s;
        case (k)
            5'd0:  begin c =  63; s =   0; end
            5'd1:  begin c =  62; s =  16; end
            5'd2:  begin c =  56; s =  31; end
            5'd3:  begin c =  47; s =  44; end
            5'd4:  begin c =  34; s =  54; end
            5'd5:  begin c =  20; s =  61; end
            5'd6:  begin c =   4; s =  63; end
            5'd7:  begin c = -12; s =  63; end
            5'd8:  begin c = -27; s =  58; end
            5'd9:  begin c = -41; s =  49; end
            5'd10: begin c = -52; s =  38; end
            5'd11: begin c = -60; s =  24; end
            5'd12: begin c = -63; s =   8; end
            5'd13: begin c = -63; s =  -8; end
            5'd14: begin c = -60; s = -24; end
            5'd15: begin c = -52; s = -38; end
            5'd16: begin c = -41; s = -49; end
            5'd17: begin c = -27; s = -58; end
            5'd18: begin c = -12; s = -63; end
            5'd19: begin c =   4; s = -64; end
            5'd20: begin c =  20; s = -61; end
            5'd21: begin c =  34; s = -54; end
            5'd22: begin c =  47; s = -44; end
            5'd23: begin c =  56; s = -31; end
            default: begin c = 62; s = -16; end
        endcase
        return '{c: coef_t'(c), s: coef_t'(s)};
    endfunction

    // Product by shifted, conditionally added copies of the coefficient.
    function automatic prod_t shift_add_mul(input coord_t v, input coef_t k);
        logic [COORD_W-1:0] mag;
        prod_t acc;
        mag = v[COORD_W-1] ? COORD_W'(-v) : COORD_W'(v);
        acc = '0;
        for (int i = 0; i < COORD_W; i++) begin
            if (mag[i]) acc = acc + (prod_t'(k) <<< i);
        end
        if (v[COORD_W-1]) acc = -acc;
        return acc;
    endfunction

endpackage

// File: rtl/pair_rot_seq.sv
module pair_rot_seq
    import pair_rot_pkg::*;
#(
    parameter int NUM_GROUPS = 64,
    parameter int PIPE_DEPTH = 9,
    localparam int GRP_W    = $clog2(NUM_GROUPS),
    localparam int CNT_W    = $clog2(NUM_GROUPS + PIPE_DEPTH),
    localparam int DONE_CNT = NUM_GROUPS + PIPE_DEPTH - 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [BIN_W-1:0] bin_i,
    output logic             busy_o,
    output logic             iss_vld_o,
    output logic             iss_last_o,
    output logic [GRP_W-1:0] iss_grp_o,
    output trig_t            trig_o
);

    logic [CNT_W-1:0] cnt_q;
    logic [BIN_W-1:0] bin_eff;

    assign bin_eff = (bin_i > BIN_W'(NUM_BINS - 1)) ? BIN_W'(NUM_BINS - 1) : bin_i;
    assign iss_last_o = iss_vld_o && (iss_grp_o == GRP_W'(NUM_GROUPS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_o    <= 1'b0;
            cnt_q     <= '0;
            iss_vld_o <= 1'b0;
            iss_grp_o <= '0;
            trig_o    <= '0;
        end else if (!busy_o) begin
            if (start_i) begin
                busy_o    <= 1'b1;
                cnt_q     <= '0;
                iss_vld_o <= 1'b1;
                iss_grp_o <= '0;
                trig_o    <= trig_lut(bin_eff);
            end
        end else begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CNT_W'(DONE_CNT)) busy_o <= 1'b0;
            if (iss_vld_o) begin
                if (iss_last_o) iss_vld_o <= 1'b0;
                else            iss_grp_o <= iss_grp_o + 1'b1;
            end
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> !iss_vld_o); // R1

    AST_GRP_STEP: assert property (@(posedge clk) disable iff (rst)
        (iss_vld_o && $past(iss_vld_o)) |-> (iss_grp_o == $past(iss_grp_o) + 1'b1)); // R9

endmodule

// File: rtl/pair_rot_lane.sv
module pair_rot_lane
    import pair_rot_pkg::*;
#(
    parameter int PT_W  = 9,
    parameter int WIN_R = 15
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PT_W-1:0] pt_idx_i,
    input  trig_t           trig_i,
    output coord_t          rx_o,
    output coord_t          ry_o
);

    localparam int SV_W = RMAG_W + 1;
    localparam int HALF = 1 << (FRAC - 1);

    point_t             s2_pt;
    trig_t              s2_tr;
    prod_t              s3_cx, s3_sy, s3_sx, s3_cy;
    sum_t               s4_sum  [2];
    logic               s5_neg  [2];
    logic [SUM_W-1:0]   s5_mag  [2];
    logic               s6_neg  [2];
    logic [RMAG_W-1:0]  s6_rmag [2];
    logic signed [SV_W-1:0] s7_val [2];
    coord_t             s8_sat  [2];

    always_ff @(posedge clk) begin
        if (rst) begin
            s2_pt <= '0;
            s2_tr <= '0;
            s3_cx <= '0;
            s3_sy <= '0;
            s3_sx <= '0;
            s3_cy <= '0;
            rx_o  <= '0;
            ry_o  <= '0;
            for (int a = 0; a < 2; a++) begin
                s4_sum[a]  <= '0;
                s5_neg[a]  <= 1'b0;
                s5_mag[a]  <= '0;
                s6_neg[a]  <= 1'b0;
                s6_rmag[a] <= '0;
                s7_val[a]  <= '0;
                s8_sat[a]  <= '0;
            end
        end else begin
            s2_pt     <= point_at(int'(pt_idx_i));
            s2_tr     <= trig_i;
            s3_cx     <= shift_add_mul(s2_pt.x, s2_tr.c);
            s3_sy     <= shift_add_mul(s2_pt.y, s2_tr.s);
            s3_sx     <= shift_add_mul(s2_pt.x, s2_tr.s);
            s3_cy     <= shift_add_mul(s2_pt.y, s2_tr.c);
            s4_sum[0] <= sum_t'(s3_cx) - sum_t'(s3_sy);
            s4_sum[1] <= sum_t'(s3_sx) + sum_t'(s3_cy);
            for (int a = 0; a < 2; a++) begin
                s5_neg[a]  <= s4_sum[a][SUM_W-1];
                s5_mag[a]  <= s4_sum[a][SUM_W-1] ? SUM_W'(-s4_sum[a]) : SUM_W'(s4_sum[a]);
                s6_neg[a]  <= s5_neg[a];
                s6_rmag[a] <= RMAG_W'((s5_mag[a] + SUM_W'(HALF)) >> FRAC);
                s7_val[a]  <= s6_neg[a] ? -$signed({1'b0, s6_rmag[a]})
                                        :  $signed({1'b0, s6_rmag[a]});
                if (s7_val[a] > SV_W'(WIN_R))       s8_sat[a] <= coord_t'(WIN_R);
                else if (s7_val[a] < -SV_W'(WIN_R)) s8_sat[a] <= -coord_t'(WIN_R);
                else                                s8_sat[a] <= coord_t'(s7_val[a]);
            end
            rx_o <= s8_sat[0];
            ry_o <= s8_sat[1];
        end
    end

    AST_SAT_RANGE: assert property (@(posedge clk) disable iff (rst)
        (rx_o <= coord_t'(WIN_R)) && (rx_o >= -coord_t'(WIN_R)) &&
        (ry_o <= coord_t'(WIN_R)) && (ry_o >= -coord_t'(WIN_R))); // R5

    AST_ROUND_NEAR: assert property (@(posedge clk) disable iff (rst)
        ((int'(s6_rmag[0]) * 64 + HALF > int'($past(s5_mag[0]))) &&
         (int'(s6_rmag[0]) * 64 <= int'($past(s5_mag[0])) + HALF))); // R4

endmodule

// File: rtl/pair_rotator.sv
module pair_rotator
    import pair_rot_pkg::*;
#(
    parameter int NUM_PAIRS  = 256,
    parameter int LANES      = 4,
    parameter int WIN_R      = 15,
    parameter int PIPE_DEPTH = 9,
    localparam int NUM_GROUPS = NUM_PAIRS / LANES,
    localparam int GRP_W      = $clog2(NUM_GROUPS),
    localparam int PT_W       = $clog2(NUM_PAIRS * 2),
    localparam int OUT_W      = LANES * 4 * COORD_W,
    localparam int CHAIN      = PIPE_DEPTH - 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [BIN_W-1:0] bin_i,
    output logic             busy_o,
    output logic             out_vld_o,
    output logic             out_done_o,
    output logic [OUT_W-1:0] out_coord_o
);

    logic             iss_vld, iss_last;
    logic [GRP_W-1:0] iss_grp;
    trig_t            iss_trig;
    logic [CHAIN-1:0] vld_sr, last_sr;

    pair_rot_seq #(
        .NUM_GROUPS (NUM_GROUPS),
        .PIPE_DEPTH (PIPE_DEPTH)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .bin_i      (bin_i),
        .busy_o     (busy_o),
        .iss_vld_o  (iss_vld),
        .iss_last_o (iss_last),
        .iss_grp_o  (iss_grp),
        .trig_o     (iss_trig)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_sr  <= '0;
            last_sr <= '0;
        end else begin
            vld_sr  <= {vld_sr[CHAIN-2:0], iss_vld};
            last_sr <= {last_sr[CHAIN-2:0], iss_last};
        end
    end

    assign out_vld_o  = vld_sr[CHAIN-1];
    assign out_done_o = last_sr[CHAIN-1];

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        for (genvar e = 0; e < 2; e++) begin : g_pt
            logic [PT_W-1:0] pt_idx;
            coord_t          rx, ry;
            assign pt_idx = PT_W'((int'(iss_grp) * LANES + j) * 2 + e);
            pair_rot_lane #(
                .PT_W  (PT_W),
                .WIN_R (WIN_R)
            ) u_rot (
                .clk      (clk),
                .rst      (rst),
                .pt_idx_i (pt_idx),
                .trig_i   (iss_trig),
                .rx_o     (rx),
                .ry_o     (ry)
            );
            assign out_coord_o[((j*2+e)*2+0)*COORD_W +: COORD_W] = rx;
            assign out_coord_o[((j*2+e)*2+1)*COORD_W +: COORD_W] = ry;
        end
    end

    AST_DONE_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
        out_done_o |-> out_vld_o); // R8

    AST_BUSY_LOW_AT_DONE: assert property (@(posedge clk) disable iff (rst)
        out_done_o |-> !busy_o); // R8

    AST_OUT_WITHIN_RUN: assert property (@(posedge clk) disable iff (rst)
        out_vld_o |-> $past(busy_o)); // R7

endmodule

// File: tb/pair_rotator_tb_top.sv
module pair_rotator_tb_top;

    localparam int LANES  = 4;
    localparam int GROUPS = 64;
    localparam int CW     = 5;
    localparam int OW     = LANES * 4 * CW;
    localparam int WIN    = 15;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [4:0]    bin = '0;
    logic          busy, out_vld, out_done;
    logic [OW-1:0] out_coord;

    pair_rotator dut_i (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start),
        .bin_i       (bin),
        .busy_o      (busy),
        .out_vld_o   (out_vld),
        .out_done_o  (out_done),
        .out_coord_o (out_coord)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0, errors = 0, sat_seen = 0;
    bit finished = 1'b0;
    logic [OW:0] exp_q[$];
    int          due_q[$];

    task automatic check(input bit ok, input string req, input logic [OW:0] act, input logic [OW:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, expv);
        end
    endtask

    function automatic int coef(input int k, input bit is_sin);
        real v;
        int r;
        v = 64.0 * (is_sin ? $sin(2.0 * 3.141592653589793 * k / 25.0)
                           : $cos(2.0 * 3.141592653589793 * k / 25.0));
        r = (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
        if (r > 63) r = 63;
        if (r < -64) r = -64;
        return r;
    endfunction

    function automatic int axis(input int num);
        int r;
        r = (num >= 0) ? (num + 32) / 64 : -((-num + 32) / 64);
        if (r > WIN || r < -WIN) sat_seen++;
        if (r > WIN) r = WIN;
        if (r < -WIN) r = -WIN;
        return r;
    endfunction

    function automatic logic [OW-1:0] group_vec(input int k, input int g);
        logic [OW-1:0] v;
        int c, s;
        c = coef(k, 1'b0);
        s = coef(k, 1'b1);
        v = '0;
        for (int j = 0; j < LANES; j++) begin
            for (int e = 0; e < 2; e++) begin
                int p, x, y, slot;
                p = (g * LANES + j) * 2 + e;
                x = ((p * 7 + 3) % 27) - 13;
                y = ((p * 5 + (p / 32) * 3 + 1) % 27) - 13;
                slot = (j * 2 + e) * 2;
                v[slot*CW +: CW]     = CW'(axis(c * x - s * y));
                v[(slot+1)*CW +: CW] = CW'(axis(s * x + c * y));
            end
        end
        return v;
    endfunction

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (out_vld) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9 unexpected group", {out_done, out_coord}, '0);
                end else begin
                    logic [OW:0] item;
                    int due;
                    item = exp_q.pop_front();
                    due  = due_q.pop_front();
                    check(out_coord == item[OW-1:0], "R2 R3 R4 R5 R6 coords", {1'b0, out_coord}, {1'b0, item[OW-1:0]});
                    check(out_done == item[OW], "R8 done flag", (OW+1)'(out_done), (OW+1)'(item[OW]));
                    check(cyc == due, "R7 arrival cycle", (OW+1)'(cyc), (OW+1)'(due));
                    if (item[OW]) check(busy == 1'b0, "R8 busy at done", (OW+1)'(busy), '0);
                end
            end else if (due_q.size() > 0 && cyc > due_q[0]) begin
                check(1'b0, "R7 missing group", (OW+1)'(cyc), (OW+1)'(due_q[0]));
                void'(exp_q.pop_front());
                void'(due_q.pop_front());
            end
        end
    end

    task automatic run(input int b, input bit poke);
        int t0, eb;
        while (busy) @(negedge clk);
        start = 1'b1;
        bin   = b[4:0];
        t0    = cyc;
        eb    = (b > 24) ? 24 : b;   // R10
        for (int g = 0; g < GROUPS; g++) begin
            exp_q.push_back({g == GROUPS - 1, group_vec(eb, g)});
            due_q.push_back(t0 + 9 + g);
        end
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R1 busy after accept", (OW+1)'(busy), (OW+1)'(1));
        if (poke) begin
            // R9: strobe with a different bin mid-run
            repeat (20) @(negedge clk);
            start = 1'b1;
            bin   = 5'd7;
            @(negedge clk);
            start = 1'b0;
        end
        while (exp_q.size() > 0) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(busy == 1'b0, "R11 busy reset", (OW+1)'(busy), '0);
        check(out_vld == 1'b0, "R11 valid reset", (OW+1)'(out_vld), '0);
        check(out_done == 1'b0, "R11 done reset", (OW+1)'(out_done), '0);
        run(0, 1'b0);
        run(3, 1'b1);
        run(12, 1'b0);
        run(19, 1'b0);
        run(24, 1'b0);
        run(30, 1'b0);
        run(6, 1'b1);
        run(18, 1'b0);
        repeat (30) @(negedge clk);
        check(sat_seen > 0, "R5 clamping exercised", (OW+1)'(sat_seen > 0), (OW+1)'(1));
        check(busy == 1'b0, "R8 idle after runs", (OW+1)'(busy), '0);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL R7 watchdog act=hung exp=complete");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule